// File: doc/BRIEF.md
# Saturating Vector Sum-Across Unit

This unit executes one vector instruction: it adds together the four signed 32-bit word lanes of a 128-bit operand A and the last word lane of a 128-bit operand B. It clamps the total to the signed 32-bit range and returns it in the last lane of a 128-bit result. The other three result lanes are zero. The unit takes a 32-bit instruction word with a valid strobe, together with the two operand values already read from the register file. One clock later it returns the result, the destination register index and a result-valid pulse.

An instruction word that does not match the opcode pattern raises a one-cycle illegal-opcode flag and produces no result. A sticky saturation status bit records any clamping. The bit stays set until software pulses a synchronous clear. If a clear and a saturating operation arrive in the same cycle, the saturation takes priority.

Top module: `vsum_sat_unit`

## Requirements
- R1: The destination index on `res_dest` is bits 25:21 of the instruction word (MSB-first bits 6–10). It appears together with the result.
- R2: A word is recognised when bits 31:26 equal 4 and bits 10:0 equal 1928. The register fields in bits 25:11 may take any value, so the pattern with zero register fields is 0x10000788. A recognised word with `instr_valid` high gives a one-cycle `res_valid` pulse one clock later.
- R3: Result lane 3 (bits 31:0) equals A.w0+A.w1+A.w2+A.w3+B.w3, all taken as signed 32-bit values. Lane 0 occupies bits 127:96 and lane 3 occupies bits 31:0.
- R4: A total above 2^31−1 gives 0x7FFFFFFF in lane 3.
- R5: A total below −2^31 gives 0x80000000 in lane 3.
- R6: Result lanes 0, 1 and 2 (bits 127:32) are zero on every valid result.
- R7: Bits 127:32 of operand B (lanes 0–2) have no effect on the result.
- R8: A valid word that does not match raises `illegal_op` for exactly one cycle, one clock later. It gives no `res_valid` and leaves `sat_flag` unchanged.
- R9: A clamped result sets `sat_flag` in the same cycle the result appears. The flag stays set through later non-saturating operations.
- R10: `sat_clear` resets `sat_flag` on the next clock. If a saturating operation is accepted in the same cycle, the flag is set instead.
- R11: The five-term total is formed wide enough that it never wraps. Terms that overflow 32 bits on the way but cancel out give the exact small result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| opnd_a | input | 128 | Operand A, four signed words, lane 0 in bits 127:96 |
| opnd_b | input | 128 | Operand B; only bits 31:0 are used |
| sat_clear | input | 1 | Synchronous clear of the saturation status bit |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | 128 | Result vector |
| res_dest | output | 5 | Destination register index |
| illegal_op | output | 1 | Unrecognised valid instruction pulse |
| sat_flag | output | 1 | Sticky saturation status |

## Verification
The summing datapath is tried with four kinds of lane values: small values near zero, values close to the positive limit, values close to the negative limit, and fully random words.

- Small values show whether lane order and sign extension are correct.
- Values near the positive limit separate a correct upper clamp from a wrapped total.
- Values near the negative limit separate a correct lower clamp from a wrapped total.
- Mixes of extreme values that cancel out separate a wide adder from one that wraps partway.

Words with random register fields are mixed with random non-matching words. This checks that only the two opcode fields decide recognition, and that a rejected word leaves the status bit alone. Directed cases then place a clear alone, a clear alongside a saturating operation, and changes to the ignored B lanes.

// File: rtl/vsum_pkg.sv
package vsum_pkg;

   localparam int unsigned INSN_W    = 32;
   localparam int unsigned REG_IDX_W = 5;

   // Instruction word, most significant field first
   typedef struct packed {
      logic [5:0]           op_major;
      logic [REG_IDX_W-1:0] rd;
      logic [REG_IDX_W-1:0] ra;
      logic [REG_IDX_W-1:0] rb;
      logic [10:0]          op_minor;
   } insn_fields_t;

endpackage

// File: rtl/vsum_decode.sv
module vsum_decode
   import vsum_pkg::*;
#(
   parameter int unsigned MAJOR_OP = 4,
   parameter int unsigned MINOR_OP = 1928
) (
   input  logic [INSN_W-1:0]    insn,
   output logic                 match,
   output logic [REG_IDX_W-1:0] dest
);

   localparam logic [5:0]  MAJOR_CODE = MAJOR_OP[5:0];
   localparam logic [10:0] MINOR_CODE = MINOR_OP[10:0];

   initial begin
      a_cfg_major: assert (MAJOR_OP < 64) else $error("major opcode too wide");
      a_cfg_minor: assert (MINOR_OP < 2048) else $error("minor opcode too wide");
   end

   insn_fields_t fields;
   assign fields = insn_fields_t'(insn);

   // source register fields select operands upstream; not needed here
   logic unused_src;
   assign unused_src = ^{fields.ra, fields.rb};

   assign match = (fields.op_major == MAJOR_CODE) && (fields.op_minor == MINOR_CODE);
   assign dest  = fields.rd;

endmodule

// File: rtl/vsum_reduce.sv
module vsum_reduce #(
   parameter int unsigned LANE_W = 32,
   parameter int unsigned LANES  = 4
) (
   input  logic [LANE_W*LANES-1:0] vec_a,
   input  logic [LANE_W-1:0]       add_b,
   output logic [LANE_W-1:0]       clamped,
   output logic                    over_pos,
   output logic                    over_neg
);

   localparam int unsigned NTERMS = LANES + 1;
   localparam int unsigned SUM_W  = LANE_W + $clog2(NTERMS) + 1;
   localparam int unsigned EXT_W  = SUM_W - LANE_W;

   localparam logic signed [SUM_W-1:0] POS_LIM = {{(EXT_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] NEG_LIM = {{(EXT_W+1){1'b1}}, {(LANE_W-1){1'b0}}};

   initial begin
      a_cfg_lane_w: assert (LANE_W >= 2) else $error("lane width too small");
      a_cfg_lanes:  assert (LANES >= 1) else $error("need at least one lane");
   end

   logic signed [SUM_W-1:0] terms [NTERMS];

   // lane 0 sits in the most significant word
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int unsigned LO = (LANES - 1 - i) * LANE_W;
      assign terms[i] = {{EXT_W{vec_a[LO+LANE_W-1]}}, vec_a[LO +: LANE_W]};
   end
   assign terms[LANES] = {{EXT_W{add_b[LANE_W-1]}}, add_b};

   logic signed [SUM_W-1:0] total;
   always_comb begin
      total = '0;
      for (int k = 0; k < NTERMS; k++) total = total + terms[k];
   end

   assign over_pos = total > POS_LIM;
   assign over_neg = total < NEG_LIM;

   always_comb begin
      if (over_pos)      clamped = {1'b0, {(LANE_W-1){1'b1}}};
      else if (over_neg) clamped = {1'b1, {(LANE_W-1){1'b0}}};
      else               clamped = total[LANE_W-1:0];
   end

endmodule

// File: rtl/vsum_sticky.sv
module vsum_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
   end

   a_r9_stays_set: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr_req |=> flag);
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag);
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req && !set_evt |=> !flag);

endmodule

// File: rtl/vsum_sat_unit.sv
module vsum_sat_unit
   import vsum_pkg::*;
#(
   parameter int unsigned LANE_W   = 32,
   parameter int unsigned LANES    = 4,
   parameter int unsigned MAJOR_OP = 4,
   parameter int unsigned MINOR_OP = 1928
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    instr_valid,
   input  logic [INSN_W-1:0]       instr_word,
   input  logic [LANE_W*LANES-1:0] opnd_a,
   input  logic [LANE_W*LANES-1:0] opnd_b,
   input  logic                    sat_clear,
   output logic                    res_valid,
   output logic [LANE_W*LANES-1:0] res_data,
   output logic [REG_IDX_W-1:0]    res_dest,
   output logic                    illegal_op,
   output logic                    sat_flag
);

   localparam int unsigned VEC_W = LANE_W * LANES;

   logic                 dec_match;
   logic [REG_IDX_W-1:0] dec_dest;

   vsum_decode #(.MAJOR_OP(MAJOR_OP), .MINOR_OP(MINOR_OP)) u_decode (
      .insn  (instr_word),
      .match (dec_match),
      .dest  (dec_dest)
   );

   logic fire, reject;
   assign fire   = instr_valid &  dec_match;
   assign reject = instr_valid & ~dec_match;

   logic [LANE_W-1:0] clamped;
   logic              over_pos, over_neg, sat_hit;

   vsum_reduce #(.LANE_W(LANE_W), .LANES(LANES)) u_reduce (
      .vec_a    (opnd_a),
      .add_b    (opnd_b[LANE_W-1:0]),
      .clamped  (clamped),
      .over_pos (over_pos),
      .over_neg (over_neg)
   );
   assign sat_hit = over_pos | over_neg;

   // only the last lane of B takes part
   logic unused_b_lanes;
   assign unused_b_lanes = ^opnd_b[VEC_W-1:LANE_W];

   logic [VEC_W-1:0] next_vec;
   for (genvar j = 0; j < LANES; j++) begin : g_out
      if (j == LANES - 1) begin : g_sum
         assign next_vec[LANE_W-1:0] = clamped;
      end else begin : g_zero
         assign next_vec[(LANES-1-j)*LANE_W +: LANE_W] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         illegal_op <= 1'b0;
         res_data   <= '0;
         res_dest   <= '0;
      end else begin
         res_valid  <= fire;
         illegal_op <= reject;
         if (fire) begin
            res_data <= next_vec;
            res_dest <= dec_dest;
         end
      end
   end

   vsum_sticky u_sticky (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (fire & sat_hit),
      .clr_req (sat_clear),
      .flag    (sat_flag)
   );

   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> res_valid && res_dest == $past(dec_dest));
   a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      reject && !sat_clear |=> illegal_op && !res_valid && $stable(sat_flag));
   a_r4_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      fire && over_pos |=> res_data[LANE_W-1:0] == {1'b0, {(LANE_W-1){1'b1}}});
   a_r5_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      fire && over_neg |=> res_data[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}});
   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_data[VEC_W-1:LANE_W] == '0);
   a_r8_one_hot_out: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_valid, illegal_op}));

endmodule

// File: tb/vsum_sat_unit_test.sv
`timescale 1ns/1ps
module vsum_sat_unit_test;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         instr_valid;
   logic [31:0]  instr_word;
   logic [127:0] opnd_a, opnd_b;
   logic         sat_clear;
   logic         res_valid;
   logic [127:0] res_data;
   logic [4:0]   res_dest;
   logic         illegal_op;
   logic         sat_flag;

   int  n_checks = 0;
   int  n_err    = 0;
   bit  exp_sat  = 1'b0;
   bit  done     = 1'b0;

   localparam logic [31:0] MAXW = 32'h7FFF_FFFF;
   localparam logic [31:0] MINW = 32'h8000_0000;
   localparam logic [31:0] BASE = 32'h1000_0788;

   always #2 clk = ~clk;

   vsum_sat_unit uut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_clear(sat_clear),
      .res_valid(res_valid), .res_data(res_data), .res_dest(res_dest),
      .illegal_op(illegal_op), .sat_flag(sat_flag)
   );

   function automatic longint lane_of(input logic [127:0] v, input int i);
      return longint'($signed(v[127-32*i -: 32]));
   endfunction

   function automatic logic [31:0] clamp32(input longint s);
      if (s > 64'sd2147483647)  return MAXW;
      if (s < -64'sd2147483648) return MINW;
      return s[31:0];
   endfunction

   function automatic bit clips(input longint s);
      return (s > 64'sd2147483647) || (s < -64'sd2147483648);
   endfunction

   function automatic logic [31:0] pick_lane();
      case ($urandom % 4)
         0: return 32'($urandom % 2000) - 32'd1000;
         1: return MAXW - ($urandom % 16);
         2: return MINW + ($urandom % 16);
         default: return $urandom;
      endcase
   endfunction

   function automatic logic [31:0] word_with(input logic [4:0] d, input logic [4:0] ra, input logic [4:0] rb);
      return {6'd4, d, ra, rb, 11'd1928};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b,
                        input bit vld, input bit clr, input string tag);
      bit legal;
      longint s;
      logic [31:0] ev;
      legal = vld && (w[31:26] == 6'd4) && (w[10:0] == 11'd1928);
      @(negedge clk);
      instr_valid = vld; instr_word = w; opnd_a = a; opnd_b = b; sat_clear = clr;
      @(negedge clk);
      instr_valid = 1'b0; sat_clear = 1'b0;
      s = lane_of(a,0) + lane_of(a,1) + lane_of(a,2) + lane_of(a,3) + lane_of(b,3);
      ev = clamp32(s);
      if (legal && clips(s)) exp_sat = 1'b1;
      else if (clr)          exp_sat = 1'b0;
      chk(res_valid == legal, {tag, " R2 res_valid"}, 128'(res_valid), 128'(legal));
      chk(illegal_op == (vld && !legal), {tag, " R8 illegal_op"}, 128'(illegal_op), 128'(vld && !legal));
      if (legal) begin
         chk(res_data == {96'b0, ev}, {tag, " R3 R6 result"}, res_data, {96'b0, ev});
         chk(res_dest == w[25:21], {tag, " R1 dest"}, 128'(res_dest), 128'(w[25:21]));
      end
      chk(sat_flag == exp_sat, {tag, " R9 R10 sat_flag"}, 128'(sat_flag), 128'(exp_sat));
   endtask

   initial begin
      rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0;
      opnd_a = '0; opnd_b = '0; sat_clear = 1'b0;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!res_valid && !illegal_op && !sat_flag && res_data == '0, "reset state",
          {res_data[123:0], res_valid, illegal_op, sat_flag, 1'b0}, '0);

      // R3 basic sum, lane order
      do_op(BASE, {32'd1, 32'd2, 32'd3, 32'd4}, {32'd100, 32'd200, 32'd300, 32'd5}, 1, 0, "basic");
      chk(res_data[31:0] == 32'd15, "R3 literal sum", 128'(res_data[31:0]), 128'd15);
      // R7 B lanes 0-2 ignored
      do_op(BASE, {32'd1, 32'd2, 32'd3, 32'd4}, {32'hDEAD_BEEF, MINW, MAXW, 32'd5}, 1, 0, "R7 b-lanes");
      chk(res_data[31:0] == 32'd15, "R7 literal sum", 128'(res_data[31:0]), 128'd15);
      // R1 destination field
      do_op(word_with(5'd17, 5'd3, 5'd29), {4{32'hFFFF_FFFF}}, '0, 1, 0, "R1 dest17");
      chk(res_dest == 5'd17, "R1 literal dest", 128'(res_dest), 128'd17);
      // R4 positive clamp, R9 set
      do_op(BASE, {4{MAXW}}, {96'b0, 32'd1}, 1, 0, "R4 pos");
      chk(res_data[31:0] == MAXW && sat_flag, "R4 R9 clamp", 128'(res_data[31:0]), 128'(MAXW));
      // R9 sticky across a clean operation
      do_op(BASE, '0, '0, 1, 0, "R9 sticky");
      chk(sat_flag == 1'b1, "R9 still set", 128'(sat_flag), 128'd1);
      // R10 clear alone
      do_op('0, '0, '0, 0, 1, "R10 clear");
      chk(sat_flag == 1'b0, "R10 cleared", 128'(sat_flag), 128'd0);
      // R5 negative clamp
      do_op(BASE, {4{MINW}}, {96'b0, 32'hFFFF_FFFF}, 1, 0, "R5 neg");
      chk(res_data[31:0] == MINW, "R5 literal", 128'(res_data[31:0]), 128'(MINW));
      // R10 clear and saturation together: set wins
      do_op('0, '0, '0, 0, 1, "R10 clear2");
      do_op(BASE, {4{MAXW}}, {96'b0, MAXW}, 1, 1, "R10 set-wins");
      chk(sat_flag == 1'b1, "R10 set wins", 128'(sat_flag), 128'd1);
      // R8 rejected words leave sat unchanged (set and clear states)
      do_op(32'h1000_0789, {4{MAXW}}, {4{MAXW}}, 1, 0, "R8 bad minor");
      do_op('0, '0, '0, 0, 1, "R10 clear3");
      do_op(32'h1400_0788, {4{MINW}}, {4{MINW}}, 1, 0, "R8 bad major");
      chk(sat_flag == 1'b0, "R8 sat untouched", 128'(sat_flag), 128'd0);
      @(negedge clk);
      chk(illegal_op == 1'b0, "R8 one-cycle pulse", 128'(illegal_op), 128'd0);
      // R11 no intermediate wrap
      do_op(BASE, {MAXW, MAXW, MINW, MINW}, '0, 1, 0, "R11 cancel");
      chk(res_data[31:0] == 32'hFFFF_FFFE, "R11 exact -2", 128'(res_data[31:0]), 128'hFFFF_FFFE);
      do_op(BASE, {MAXW, MAXW, MINW, MINW}, {96'b0, 32'd1}, 1, 0, "R11 cancel2");
      do_op(BASE, {4{MAXW}}, {96'b0, MINW}, 1, 0, "R11 R4 wide");

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] w;
         logic [127:0] a, b;
         if ($urandom % 5 == 0) w = $urandom;
         else w = word_with(5'($urandom), 5'($urandom), 5'($urandom));
         a = {pick_lane(), pick_lane(), pick_lane(), pick_lane()};
         b = {pick_lane(), pick_lane(), pick_lane(), pick_lane()};
         do_op(w, a, b, ($urandom % 8) != 0, ($urandom % 6) == 0, "rand");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

endmodule